// File: doc/BRIEF.md
# X-First Mesh Route Encoder

This block turns a pair of mesh coordinates into the source-route field that travels in the head flit of a packet. It is given the sender's own position in a rectangular mesh of routers and the coordinate of the destination cluster. It writes out the list of per-router turn decisions that carry the packet there. The path always finishes every X step before any Y step, which keeps the network free of deadlock. The last router on the path hands the packet to its local port.

Each router decision is a 2-bit code that is relative to the port the packet arrived on. The five router ports form a fixed ring. A code selects one of the four ports that follow the arrival port around that ring. The route field holds at most nine such codes. A coordinate outside the mesh, or a path that needs more than nine decisions, is flagged as an error and produces no route. The block has one register stage: a request presented in one cycle gives its route on the outputs after the next clock edge.

Top module: `mesh_route_encoder`

## Requirements
- R1: While reset is asserted and after its release until the first request, `rsp_valid`, `rsp_err`, `rsp_hops` and `rsp_path` are all zero.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. `rsp_path`, `rsp_hops` and `rsp_err` change only after a request and otherwise hold their last values.
- R3: For a valid request whose source and destination differ, `rsp_hops` equals |dst_x−src_x| + |dst_y−src_y| + 1, which counts one decision per router visited.
- R4: The path takes every X step before any Y step. East is +X and north is +Y.
- R5: The ports are numbered around a ring: local=0, east=1, north=2, west=3, south=4. A decision that enters on port `in` and leaves on port `out` is coded as (out − in − 1) mod 5. The first decision enters on the local port. Every later decision enters on the port that faces the previous router.
- R6: Decision k occupies bits [2k+1:2k], so the first decision sits in bits [1:0]. The final decision leaves on the local port. All slots at or above `rsp_hops` are zero.
- R7: When the destination equals the source and both lie inside the mesh, `rsp_hops` is 0, `rsp_path` is 0 and `rsp_err` is 0. The wrapper delivers locally.
- R8: `rsp_err` is set, and `rsp_path` and `rsp_hops` are forced to zero, when any source or destination coordinate lies outside the mesh, or when the path would need more than 9 decisions.
- R9: An error-free response never reports more decisions than MESH_W + MESH_H − 1. The parameters must satisfy MESH_W + MESH_H − 1 ≤ 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; captures the coordinates |
| src_x | input | COORD_W | Sender column, strapped per instance |
| src_y | input | COORD_W | Sender row, strapped per instance |
| dst_x | input | COORD_W | Destination cluster column |
| dst_y | input | COORD_W | Destination cluster row |
| rsp_valid | output | 1 | Route available this cycle |
| rsp_path | output | 18 | Packed decision codes, first in bits [1:0] |
| rsp_hops | output | 4 | Number of decisions in the path |
| rsp_err | output | 1 | Destination unreachable or coordinate out of range |

## Verification
The bench builds the encoder as a 5-by-4 mesh, which sums to 8 decisions at most, with 4-bit coordinates. Coordinate values 5 to 15 for X and 4 to 15 for Y therefore reach the range error. Some of them also push the raw decision count past nine, so both error causes are exercised. Inside the mesh, the corner-to-corner routes reach the longest legal path. The random source and destination pairs cover every direction of each X and Y leg, including pure-X, pure-Y and loopback cases.

// File: rtl/mre_pkg.sv
package mre_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_NORTH = 3'd2,
    PORT_WEST  = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  // Port on which a packet arrives after leaving a neighbour through p.
  function automatic port_e facing_port(input port_e p);
    port_e r;
    case (p)
      PORT_EAST:  r = PORT_WEST;
      PORT_WEST:  r = PORT_EAST;
      PORT_NORTH: r = PORT_SOUTH;
      PORT_SOUTH: r = PORT_NORTH;
      default:    r = PORT_LOCAL;
    endcase
    return r;
  endfunction

  // Relative decision code: position of out after in around the port ring, minus one.
  function automatic logic [CODE_W-1:0] ring_code(input port_e in_p, input port_e out_p);
    logic [3:0] d;
    d = {1'b0, out_p} + 4'd5 - {1'b0, in_p};
    if (d >= 4'd5) d = d - 4'd5;
    if (d == 4'd0) return '0;
    return CODE_W'(d - 4'd1);
  endfunction

endpackage

// File: rtl/mre_span_calc.sv
module mre_span_calc
  import mre_pkg::*;
#(
  parameter int MESH_W   = 5,
  parameter int MESH_H   = 4,
  parameter int COORD_W  = 4,
  parameter int MAX_HOPS = 9,
  localparam int SUM_W   = COORD_W + 2
) (
  input  logic [COORD_W-1:0] src_x,
  input  logic [COORD_W-1:0] src_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic [SUM_W-1:0]   x_steps,
  output logic [SUM_W-1:0]   y_steps,
  output port_e              x_dir,
  output port_e              y_dir,
  output logic [SUM_W-1:0]   hop_total,
  output logic               loopback,
  output logic               unreachable
);

  localparam logic [COORD_W:0] W_LIM = (COORD_W+1)'(MESH_W);
  localparam logic [COORD_W:0] H_LIM = (COORD_W+1)'(MESH_H);
  localparam logic [SUM_W-1:0] HOP_LIM = SUM_W'(MAX_HOPS);

  logic x_fwd, y_fwd;
  logic out_of_range;
  logic [SUM_W-1:0] raw_total;

  always_comb begin
    x_fwd = dst_x >= src_x;
    y_fwd = dst_y >= src_y;
    x_steps = x_fwd ? SUM_W'(dst_x - src_x) : SUM_W'(src_x - dst_x);
    y_steps = y_fwd ? SUM_W'(dst_y - src_y) : SUM_W'(src_y - dst_y);
    x_dir = x_fwd ? PORT_EAST : PORT_WEST;
    y_dir = y_fwd ? PORT_NORTH : PORT_SOUTH;

    out_of_range = ({1'b0, src_x} >= W_LIM) || ({1'b0, dst_x} >= W_LIM) ||
                   ({1'b0, src_y} >= H_LIM) || ({1'b0, dst_y} >= H_LIM);
    loopback  = (src_x == dst_x) && (src_y == dst_y);
    raw_total = x_steps + y_steps + SUM_W'(1);

    unreachable = out_of_range || (!loopback && (raw_total > HOP_LIM));
    hop_total   = (unreachable || loopback) ? '0 : raw_total;
  end

endmodule

// File: rtl/mre_slot_encoder.sv
module mre_slot_encoder
  import mre_pkg::*;
#(
  parameter int COORD_W = 4,
  parameter int SLOT    = 0,
  localparam int SUM_W  = COORD_W + 2
) (
  input  logic [SUM_W-1:0]  x_steps,
  input  logic [SUM_W-1:0]  y_steps,
  input  port_e             x_dir,
  input  port_e             y_dir,
  input  logic [SUM_W-1:0]  hop_total,
  output logic [CODE_W-1:0] code
);

  localparam logic [SUM_W-1:0] K      = SUM_W'(SLOT);
  localparam logic [SUM_W-1:0] K_PREV = SUM_W'(SLOT == 0 ? 0 : SLOT - 1);

  port_e in_p, out_p, prev_out;
  logic  active;

  always_comb begin
    active = K < hop_total;

    if (K < x_steps)                 out_p = x_dir;
    else if (K < x_steps + y_steps)  out_p = y_dir;
    else                             out_p = PORT_LOCAL;

    prev_out = (K_PREV < x_steps) ? x_dir : y_dir;
    in_p     = (SLOT == 0) ? PORT_LOCAL : facing_port(prev_out);

    code = active ? ring_code(in_p, out_p) : '0;
  end

endmodule

// File: rtl/mre_out_reg.sv
module mre_out_reg #(
  parameter int PATH_W = 18,
  parameter int HOPS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PATH_W-1:0] path_d,
  input  logic [HOPS_W-1:0] hops_d,
  input  logic              err_d,
  output logic              valid_q,
  output logic [PATH_W-1:0] path_q,
  output logic [HOPS_W-1:0] hops_q,
  output logic              err_q
);

  logic [PATH_W-1:0] path_n;
  logic [HOPS_W-1:0] hops_n;
  logic              err_n;

  always_comb begin
    path_n = path_q;
    hops_n = hops_q;
    err_n  = err_q;
    if (load) begin
      path_n = path_d;
      hops_n = hops_d;
      err_n  = err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      path_q  <= '0;
      hops_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= load;
      path_q  <= path_n;
      hops_q  <= hops_n;
      err_q   <= err_n;
    end
  end

endmodule

// File: rtl/mesh_route_encoder.sv
module mesh_route_encoder
  import mre_pkg::*;
#(
  parameter int MESH_W   = 5,
  parameter int MESH_H   = 4,
  parameter int COORD_W  = 4,
  parameter int MAX_HOPS = 9,
  localparam int PATH_W  = MAX_HOPS * CODE_W,
  localparam int HOPS_W  = $clog2(MAX_HOPS + 1),
  localparam int SUM_W   = COORD_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [COORD_W-1:0] src_x,
  input  logic [COORD_W-1:0] src_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic               rsp_valid,
  output logic [PATH_W-1:0]  rsp_path,
  output logic [HOPS_W-1:0]  rsp_hops,
  output logic               rsp_err
);

  if (MESH_W + MESH_H - 1 > MAX_HOPS) begin : g_bad_mesh
    $error("mesh_route_encoder: MESH_W + MESH_H - 1 exceeds MAX_HOPS");
  end

  logic [SUM_W-1:0]  x_steps, y_steps, hop_total;
  port_e             x_dir, y_dir;
  logic              loopback, unreachable;
  logic [PATH_W-1:0] path_d;
  logic [HOPS_W-1:0] hops_d;

  mre_span_calc #(
    .MESH_W(MESH_W), .MESH_H(MESH_H), .COORD_W(COORD_W), .MAX_HOPS(MAX_HOPS)
  ) span_i (
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .x_steps(x_steps), .y_steps(y_steps), .x_dir(x_dir), .y_dir(y_dir),
    .hop_total(hop_total), .loopback(loopback), .unreachable(unreachable)
  );

  for (genvar s = 0; s < MAX_HOPS; s++) begin : g_slot
    mre_slot_encoder #(.COORD_W(COORD_W), .SLOT(s)) slot_i (
      .x_steps(x_steps), .y_steps(y_steps), .x_dir(x_dir), .y_dir(y_dir),
      .hop_total(hop_total), .code(path_d[s*CODE_W +: CODE_W])
    );
  end

  assign hops_d = HOPS_W'(hop_total);

  mre_out_reg #(.PATH_W(PATH_W), .HOPS_W(HOPS_W)) out_i (
    .clk(clk), .rst_n(rst_n), .load(req_valid),
    .path_d(path_d), .hops_d(hops_d), .err_d(unreachable),
    .valid_q(rsp_valid), .path_q(rsp_path), .hops_q(rsp_hops), .err_q(rsp_err)
  );

  logic unused_loop;
  assign unused_loop = loopback;

endmodule

// File: rtl/mre_checker.sv
module mre_checker #(
  parameter int MESH_W  = 5,
  parameter int MESH_H  = 4,
  parameter int PATH_W  = 18,
  parameter int HOPS_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic [PATH_W-1:0] rsp_path,
  input logic [HOPS_W-1:0] rsp_hops,
  input logic              rsp_err
);

  localparam logic [HOPS_W-1:0] LONGEST = HOPS_W'(MESH_W + MESH_H - 1);

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_path) && $stable(rsp_hops) && $stable(rsp_err)));

  // R8
  err_clears_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_path == '0 && rsp_hops == '0));

  // R9
  hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (rsp_hops <= LONGEST));

  // R6
  empty_route_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hops == '0) |-> (rsp_path == '0));

endmodule

bind mesh_route_encoder mre_checker #(
  .MESH_W(MESH_W), .MESH_H(MESH_H), .PATH_W(PATH_W), .HOPS_W(HOPS_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_path(rsp_path), .rsp_hops(rsp_hops), .rsp_err(rsp_err)
);

// File: tb/mesh_route_encoder_tb_top.sv
module mesh_route_encoder_tb_top;

  localparam int MW = 5;
  localparam int MH = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [CW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0;
  logic          rsp_valid;
  logic [17:0]   rsp_path;
  logic [3:0]    rsp_hops;
  logic          rsp_err;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mesh_route_encoder #(.MESH_W(MW), .MESH_H(MH), .COORD_W(CW), .MAX_HOPS(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .rsp_valid(rsp_valid), .rsp_path(rsp_path), .rsp_hops(rsp_hops), .rsp_err(rsp_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Code of a turn (R5): which of the four ports after in_p around the ring is out_p.
  function automatic int code_of(input int in_p, input int out_p);
    for (int c = 0; c < 4; c++)
      if ((in_p + 1 + c) % 5 == out_p) return c;
    return -1;
  endfunction

  function automatic int opposite(input int p);
    return ((p + 1) % 4) + 1;
  endfunction

  function automatic bit exp_err(input int sx, sy, dx, dy);
    int h;
    h = (sx > dx ? sx - dx : dx - sx) + (sy > dy ? sy - dy : dy - sy) + 1;
    if (sx >= MW || dx >= MW || sy >= MH || dy >= MH) return 1'b1;
    if (!(sx == dx && sy == dy) && h > 9) return 1'b1;
    return 1'b0;
  endfunction

  // Walk the mesh X first, then Y (R4), then eject to local (R6).
  task automatic expect_route(input int sx, sy, dx, dy,
                              output logic [17:0] path, output int hops, output bit err);
    int cx, cy, inp, outp;
    path = '0; hops = 0; err = exp_err(sx, sy, dx, dy);
    if (err || (sx == dx && sy == dy)) return;
    cx = sx; cy = sy; inp = 0;
    for (int k = 0; k < 9; k++) begin
      if (cx < dx)      begin outp = 1; cx++; end
      else if (cx > dx) begin outp = 3; cx--; end
      else if (cy < dy) begin outp = 2; cy++; end
      else if (cy > dy) begin outp = 4; cy--; end
      else              outp = 0;
      path[2*k +: 2] = 2'(code_of(inp, outp));
      hops++;
      if (outp == 0) break;
      inp = opposite(outp);
    end
  endtask

  task automatic run_one(input int sx, sy, dx, dy, input string tag);
    logic [17:0] ep; int eh; bit ee;
    @(negedge clk);
    src_x = CW'(sx); src_y = CW'(sy); dst_x = CW'(dx); dst_y = CW'(dy);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    expect_route(sx, sy, dx, dy, ep, eh, ee);
    check({tag, " R2 valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " R8 err"}, 32'(rsp_err), 32'(ee));
    check({tag, " R3 hops"}, 32'(rsp_hops), 32'(eh));
    check({tag, " R5 path"}, 32'(rsp_path), 32'(ep));
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [17:0] held_path;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 valid in reset", 32'(rsp_valid), 32'd0);
    check("R1 path in reset", 32'(rsp_path), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after release", 32'(rsp_valid), 32'd0);
    check("R1 hops after release", 32'(rsp_hops), 32'd0);
    check("R1 err after release", 32'(rsp_err), 32'd0);

    // R4 R5 R6: one east step then local: E from local=0, local from west=1
    run_one(1, 1, 2, 1, "east1");
    check("R6 east1 literal", 32'(rsp_path), 32'h4);
    // R4: west then north: W from local=2, N from east=0, local from south=0
    run_one(2, 1, 1, 2, "west_north");
    check("R4 west_north literal", 32'(rsp_path), 32'h2);
    run_one(0, 0, 4, 3, "corner_ne");       // R9 longest legal path: 8 decisions
    check("R9 longest hops", 32'(rsp_hops), 32'd8);
    run_one(4, 3, 0, 0, "corner_sw");
    run_one(2, 0, 2, 3, "pure_north");
    run_one(2, 3, 2, 0, "pure_south");
    run_one(3, 2, 3, 2, "R7 loopback");
    run_one(1, 1, 5, 1, "R8 dst_x range");
    run_one(0, 4, 0, 0, "R8 src_y range");
    run_one(0, 0, 15, 15, "R8 over limit");

    // R2 hold: idle cycles keep the last route, valid stays low
    run_one(1, 0, 3, 2, "pre_hold");
    held_path = rsp_path;
    repeat (3) @(negedge clk);
    check("R2 idle valid low", 32'(rsp_valid), 32'd0);
    check("R2 idle path held", 32'(rsp_path), 32'(held_path));

    for (int i = 0; i < 400; i++) begin
      int sx, sy, dx, dy;
      if ($urandom_range(0, 9) < 8) begin
        sx = $urandom_range(0, MW-1); sy = $urandom_range(0, MH-1);
        dx = $urandom_range(0, MW-1); dy = $urandom_range(0, MH-1);
      end else begin
        sx = $urandom_range(0, 15); sy = $urandom_range(0, 15);
        dx = $urandom_range(0, 15); dy = $urandom_range(0, 15);
      end
      run_one(sx, sy, dx, dy, "rand R3 R4 R6 R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule